// File: doc/BRIEF.md
# Status-Decoding Bus Command Controller

This block sits beside a processor that encodes each bus cycle as a 3-bit status code rather than driving its own strobes. It watches the code on every processor clock. A change from the passive code to any other code marks the start of a cycle. From the code captured at that moment and a count of clocks since the start, it produces separate command strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces an address latch pulse, an active-high data enable and a data direction level.

Two extra write strobes go active one clock before the normal writes, for devices that need a wider write pulse. One output has two roles that depend on the mode. In local I/O bus mode it is a peripheral data enable that follows the data enable. In shared system bus mode it is a cascade enable, raised in the first clock of an interrupt-acknowledge cycle. In system bus mode an active-low address enable, after a configurable number of clocks, releases the command drivers. The block does not drive tri-state pins: it reports that state as an output-enable level. A command enable input forces all commands and both data enables inactive.

Top module: `bus_cmd_ctrl`

## Requirements
- R1: While reset is active and right after it, every command strobe, latch_en, data_en and casc_pden is 0 and dir_xmit is 1. cmd_oe is 0 in system bus mode with addr_en_n high.
- R2: The status code is decoded as follows: 0 interrupt acknowledge, 1 I/O read, 2 I/O write, 3 halt (no command), 4 code fetch (drives mem_rd), 5 memory read, 6 memory write, 7 passive. At most one of mem_rd, mem_wr, io_rd, io_wr, int_ack is high at a time.
- R3: latch_en is high during only the first clock after a passive-to-non-passive change, and only for codes other than halt.
- R4: Counting the first clock as clock 1, read, interrupt-acknowledge and advanced write strobes go high from clock 2. Normal writes go high from clock 3. All strobes are low in the clock after the code returns to passive.
- R5: dir_xmit is 0 during read, fetch and interrupt-acknowledge cycles, and 1 during write cycles, halt and idle.
- R6: data_en is cmd_en AND (write cycle from clock 2, or read/fetch/acknowledge cycle from clock 3). It is low when idle.
- R7: When io_bus_mode is 1, casc_pden equals data_en. When io_bus_mode is 0, it is high only in clock 1 of an interrupt-acknowledge cycle with cmd_en high.
- R8: When io_bus_mode is 0, cmd_oe equals NOT addr_en_n as sampled one clock earlier, and commands are forced low while cmd_oe is 0. When io_bus_mode is 1, cmd_oe is 1 and addr_en_n has no effect.
- R9: While cmd_en is 0, all command strobes are 0. latch_en and dir_xmit are not affected by cmd_en.
- R10: The code is captured at cycle start. A change to another non-passive code without passing through passive neither restarts the cycle nor changes which commands are driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_status | input | 3 | Bus-cycle status code |
| addr_en_n | input | 1 | Address enable, active low (system bus mode only) |
| cmd_en | input | 1 | Command enable, active high |
| io_bus_mode | input | 1 | 1 = local I/O bus mode, 0 = system bus mode |
| mem_rd | output | 1 | Memory read command |
| mem_wr | output | 1 | Memory write command |
| adv_mem_wr | output | 1 | Advanced memory write command |
| io_rd | output | 1 | I/O read command |
| io_wr | output | 1 | I/O write command |
| adv_io_wr | output | 1 | Advanced I/O write command |
| int_ack | output | 1 | Interrupt acknowledge command |
| latch_en | output | 1 | Address latch enable pulse |
| data_en | output | 1 | Data transceiver enable, active high |
| dir_xmit | output | 1 | Data direction: 1 transmit, 0 receive |
| casc_pden | output | 1 | Cascade enable or peripheral data enable, depending on mode |
| cmd_oe | output | 1 | Command driver output enable |

## Verification
Two events can land in the same clock: the address-enable release reaching the command drivers, and the clock in which a memory read would first assert. The bench runs a memory read cycle in system bus mode with addr_en_n held high. It drops addr_en_n right after sampling clock 2. It then expects mem_rd and cmd_oe to stay low at clock 2 and to rise together at clock 3. A full sweep of every status code against every combination of mode, command enable and address enable judges the other outputs clock by clock.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

   localparam int STAT_W = 3;

   typedef enum logic [STAT_W-1:0] {
      ST_INTA  = 3'd0,
      ST_IORD  = 3'd1,
      ST_IOWR  = 3'd2,
      ST_HALT  = 3'd3,
      ST_FETCH = 3'd4,
      ST_MEMRD = 3'd5,
      ST_MEMWR = 3'd6,
      ST_IDLE  = 3'd7
   } bus_stat_e;

   typedef struct packed {
      logic mem_rd;
      logic mem_wr;
      logic io_rd;
      logic io_wr;
      logic inta;
      logic is_read;
      logic is_write;
      logic has_cmd;
   } cyc_kind_t;

endpackage

// File: rtl/bcc_decode.sv
module bcc_decode
   import bcc_pkg::*;
(
   input  logic [STAT_W-1:0] code,
   output cyc_kind_t         kind
);

   always_comb begin
      kind = '0;
      case (bus_stat_e'(code))
         ST_INTA:  begin kind.inta   = 1'b1; kind.is_read  = 1'b1; end
         ST_IORD:  begin kind.io_rd  = 1'b1; kind.is_read  = 1'b1; end
         ST_IOWR:  begin kind.io_wr  = 1'b1; kind.is_write = 1'b1; end
         ST_FETCH: begin kind.mem_rd = 1'b1; kind.is_read  = 1'b1; end
         ST_MEMRD: begin kind.mem_rd = 1'b1; kind.is_read  = 1'b1; end
         ST_MEMWR: begin kind.mem_wr = 1'b1; kind.is_write = 1'b1; end
         default:  kind = '0;
      endcase
      kind.has_cmd = kind.is_read | kind.is_write;
   end

endmodule

// File: rtl/bcc_phase.sv
module bcc_phase
   import bcc_pkg::*;
#(
   parameter int PH_MAX = 3,
   localparam int PH_W = $clog2(PH_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] status,
   output logic [PH_W-1:0]   phase,
   output logic [STAT_W-1:0] code_q
);

   logic [STAT_W-1:0] stat_q;
   logic              now_idle;
   logic              was_idle;

   assign now_idle = (status == ST_IDLE);
   assign was_idle = (stat_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= ST_IDLE;
         code_q <= ST_IDLE;
         phase  <= '0;
      end else begin
         stat_q <= status;
         if (now_idle) begin
            phase  <= '0;
            code_q <= ST_IDLE;
         end else if (was_idle) begin
            phase  <= PH_W'(1);
            code_q <= status;
         end else if (phase != '0 && phase < PH_W'(PH_MAX)) begin
            phase <= phase + PH_W'(1);
         end
      end
   end

   // R10
   code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != '0 && status != ST_IDLE) |=> $stable(code_q));

   // R4
   phase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      now_idle |=> (phase == '0));

endmodule

// File: rtl/bcc_gate.sv
module bcc_gate #(
   parameter int AEN_DELAY = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic addr_en_n,
   input  logic io_bus_mode,
   output logic cmd_oe
);

   logic aen_ok;

   generate
      if (AEN_DELAY == 0) begin : g_direct
         assign aen_ok = ~addr_en_n;
      end else begin : g_sync
         logic [AEN_DELAY-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sr <= '0;
            end else begin
               sr[0] <= ~addr_en_n;
               for (int i = 1; i < AEN_DELAY; i++) sr[i] <= sr[i-1];
            end
         end
         assign aen_ok = sr[AEN_DELAY-1];
      end
   endgenerate

   assign cmd_oe = io_bus_mode | aen_ok;

   generate
      if (AEN_DELAY == 1) begin : g_chk
         // R8
         aen_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!io_bus_mode && addr_en_n) |=> (io_bus_mode || !cmd_oe));
         // R8
         aen_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!addr_en_n) |=> cmd_oe);
      end
   endgenerate

endmodule

// File: rtl/bus_cmd_ctrl.sv
module bus_cmd_ctrl
   import bcc_pkg::*;
#(
   parameter int AEN_DELAY = 1,
   parameter int WR_LAG    = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] cyc_status,
   input  logic              addr_en_n,
   input  logic              cmd_en,
   input  logic              io_bus_mode,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic              adv_mem_wr,
   output logic              io_rd,
   output logic              io_wr,
   output logic              adv_io_wr,
   output logic              int_ack,
   output logic              latch_en,
   output logic              data_en,
   output logic              dir_xmit,
   output logic              casc_pden,
   output logic              cmd_oe
);

   localparam int PH_EARLY = 2;
   localparam int PH_RDEN  = 3;
   localparam int PH_NWR   = PH_EARLY + WR_LAG;
   localparam int PH_MAX   = (PH_NWR > PH_RDEN) ? PH_NWR : PH_RDEN;
   localparam int PH_W     = $clog2(PH_MAX + 1);

   generate
      if (WR_LAG < 1 || WR_LAG > 4) begin : g_bad_lag
         $error("WR_LAG must lie in 1..4");
      end
      if (AEN_DELAY < 0 || AEN_DELAY > 8) begin : g_bad_aen
         $error("AEN_DELAY must lie in 0..8");
      end
   endgenerate

   logic [PH_W-1:0]   phase;
   logic [STAT_W-1:0] code_q;
   cyc_kind_t         kind;
   logic              active, early, late, rd_late, gate;

   bcc_phase #(.PH_MAX(PH_MAX)) u_phase (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (cyc_status),
      .phase  (phase),
      .code_q (code_q)
   );

   bcc_decode u_dec (
      .code (code_q),
      .kind (kind)
   );

   bcc_gate #(.AEN_DELAY(AEN_DELAY)) u_gate (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_en_n   (addr_en_n),
      .io_bus_mode (io_bus_mode),
      .cmd_oe      (cmd_oe)
   );

   assign active  = (phase != '0);
   assign early   = (phase >= PH_W'(PH_EARLY));
   assign late    = (phase >= PH_W'(PH_NWR));
   assign rd_late = (phase >= PH_W'(PH_RDEN));
   assign gate    = cmd_en & cmd_oe;

   assign mem_rd     = gate & kind.mem_rd & early;
   assign io_rd      = gate & kind.io_rd  & early;
   assign int_ack    = gate & kind.inta   & early;
   assign adv_mem_wr = gate & kind.mem_wr & early;
   assign adv_io_wr  = gate & kind.io_wr  & early;
   assign mem_wr     = gate & kind.mem_wr & late;
   assign io_wr      = gate & kind.io_wr  & late;

   assign latch_en = kind.has_cmd & (phase == PH_W'(1));
   assign dir_xmit = ~(active & kind.is_read);
   assign data_en  = cmd_en & ((kind.is_write & early) | (kind.is_read & rd_late));

   generate
      if (1) begin : g_dual
         assign casc_pden = io_bus_mode ? data_en : (cmd_en & latch_en & kind.inta);
      end
   endgenerate

   // R2
   cmd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_rd, mem_wr, io_rd, io_wr, int_ack}));

   // R3
   ale_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      latch_en |=> !latch_en);

   // R4
   wr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr |-> adv_mem_wr) and (io_wr |-> adv_io_wr));

   // R4
   passive_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_status == ST_IDLE) |=>
         !(mem_rd | mem_wr | adv_mem_wr | io_rd | io_wr | adv_io_wr | int_ack));

   // R5
   dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd | io_rd | int_ack) |-> !dir_xmit);

   // R7
   casc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!io_bus_mode && casc_pden) |-> latch_en);

endmodule

// File: tb/sim_bus_cmd_ctrl.sv
module sim_bus_cmd_ctrl;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cyc_status = 3'd7;
   logic       addr_en_n = 1'b1;
   logic       cmd_en = 1'b1;
   logic       io_bus_mode = 1'b0;
   logic mem_rd, mem_wr, adv_mem_wr, io_rd, io_wr, adv_io_wr, int_ack;
   logic latch_en, data_en, dir_xmit, casc_pden, cmd_oe;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   bus_cmd_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .cyc_status(cyc_status), .addr_en_n(addr_en_n),
      .cmd_en(cmd_en), .io_bus_mode(io_bus_mode), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .adv_mem_wr(adv_mem_wr), .io_rd(io_rd), .io_wr(io_wr), .adv_io_wr(adv_io_wr),
      .int_ack(int_ack), .latch_en(latch_en), .data_en(data_en), .dir_xmit(dir_xmit),
      .casc_pden(casc_pden), .cmd_oe(cmd_oe)
   );

   task automatic check(string tag, logic [6:0] act, logic [6:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic bit is_rd(int c);
      return (c == 0 || c == 1 || c == 4 || c == 5);
   endfunction

   function automatic bit is_wr(int c);
      return (c == 2 || c == 6);
   endfunction

   // order: mem_rd mem_wr adv_mem_wr io_rd io_wr adv_io_wr int_ack
   function automatic logic [6:0] e_cmd(int c, int k, bit iob, bit cen, bit aenn);
      logic [6:0] r;
      bit e, l;
      r = '0;
      e = (k >= 2);
      l = (k >= 3);
      if (!(cen && (iob || !aenn)) || k == 0) return r;
      case (c)
         0: r[0] = e;
         1: r[3] = e;
         2: begin r[2] = l; r[1] = e; end
         4, 5: r[6] = e;
         6: begin r[5] = l; r[4] = e; end
         default: r = '0;
      endcase
      return r;
   endfunction

   task automatic check_all(int c, int k, bit iob, bit cen, bit aenn);
      bit den, ale;
      ale = (k == 1) && c != 3 && c != 7;
      den = cen && ((is_wr(c) && k >= 2) || (is_rd(c) && k >= 3));
      check($sformatf("R2 R4 R9 commands code=%0d k=%0d", c, k),
            {mem_rd, mem_wr, adv_mem_wr, io_rd, io_wr, adv_io_wr, int_ack},
            e_cmd(c, k, iob, cen, aenn));
      check($sformatf("R3 latch_en code=%0d k=%0d", c, k), 7'(latch_en), 7'(ale));
      check($sformatf("R5 dir_xmit code=%0d k=%0d", c, k), 7'(dir_xmit),
            7'(!(k >= 1 && is_rd(c))));
      check($sformatf("R6 data_en code=%0d k=%0d cen=%0d", c, k, cen), 7'(data_en), 7'(den));
      check($sformatf("R7 casc_pden code=%0d k=%0d iob=%0d", c, k, iob), 7'(casc_pden),
            7'(iob ? den : (cen && k == 1 && c == 0)));
      check($sformatf("R8 cmd_oe iob=%0d aenn=%0d", iob, aenn), 7'(cmd_oe),
            7'(iob || !aenn));
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state, sampled while reset is held
      check_all(7, 0, 0, 1, 1);
      rst_n = 1'b1;
      step();
      // R1: right after reset
      check_all(7, 0, 0, 1, 1);

      // Full sweep, covering R2 R3 R4 R5 R6 R7 R8 R9
      for (int iob = 0; iob < 2; iob++) begin
         for (int cen = 0; cen < 2; cen++) begin
            for (int aenn = 0; aenn < 2; aenn++) begin
               for (int c = 0; c < 7; c++) begin
                  io_bus_mode = iob[0];
                  cmd_en = cen[0];
                  addr_en_n = aenn[0];
                  cyc_status = 3'd7;
                  step();
                  step();
                  check_all(7, 0, iob[0], cen[0], aenn[0]);
                  cyc_status = 3'(c);
                  for (int k = 1; k <= 4; k++) begin
                     step();
                     check_all(c, k, iob[0], cen[0], aenn[0]);
                  end
                  cyc_status = 3'd7;
                  step();
                  check_all(c, 0, iob[0], cen[0], aenn[0]);
               end
            end
         end
      end

      // R8: address enable released mid-cycle, system bus mode, one clock delay
      io_bus_mode = 1'b0;
      cmd_en = 1'b1;
      addr_en_n = 1'b1;
      step();
      step();
      cyc_status = 3'd5;
      step();
      step();
      check("R8 mem_rd held while drivers off k=2", 7'(mem_rd), 7'd0);
      check("R8 cmd_oe low k=2", 7'(cmd_oe), 7'd0);
      addr_en_n = 1'b0;
      step();
      check("R8 mem_rd after release k=3", 7'(mem_rd), 7'd1);
      check("R8 cmd_oe after release k=3", 7'(cmd_oe), 7'd1);
      cyc_status = 3'd7;
      step();
      check("R4 mem_rd clear after passive", 7'(mem_rd), 7'd0);

      // R10: non-passive to non-passive change does not restart
      cyc_status = 3'd5;
      step();
      step();
      step();
      cyc_status = 3'd6;
      step();
      check("R10 no latch pulse on code change", 7'(latch_en), 7'd0);
      check("R10 commands keep captured code",
            {mem_rd, mem_wr, adv_mem_wr, io_rd, io_wr, adv_io_wr, int_ack}, 7'b1000000);
      step();
      check("R10 commands still captured code",
            {mem_rd, mem_wr, adv_mem_wr, io_rd, io_wr, adv_io_wr, int_ack}, 7'b1000000);
      cyc_status = 3'd7;
      step();
      check("R4 idle after passive", {mem_rd, mem_wr, adv_mem_wr, io_rd, io_wr,
            adv_io_wr, int_ack}, 7'd0);

      // R9: cmd_en toggled low mid-cycle drops commands, ALE/direction untouched
      cyc_status = 3'd1;
      step();
      cmd_en = 1'b0;
      step();
      check("R9 io_rd forced off", 7'(io_rd), 7'd0);
      check("R9 dir_xmit unaffected", 7'(dir_xmit), 7'd0);
      cmd_en = 1'b1;
      step();
      check("R9 io_rd back on", 7'(io_rd), 7'd1);
      cyc_status = 3'd7;
      step();

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule